// File: doc/BRIEF.md
# Serial Control-Word Latch Loader

This block receives configuration words over a three-wire serial port (serial clock, serial data, load strobe) and distributes each word to one of seven parallel holding registers. Bits are sampled on rising serial-clock edges into a shift register, most significant bit first. The final three bits of each frame therefore form an address field that picks the destination register.

A rising edge on the load strobe copies the payload into the addressed register. The payload is every bit above the address field. A one-cycle update pulse tells downstream logic which register just changed. All three port wires are asynchronous to the system clock. They are brought into the system domain through two-flop synchronizers, and edges are detected there.

After reset, the shift register is empty and each holding register carries a parameter-chosen default.

Top module: `ser_cfg_loader`

## Requirements
- R1: After reset, holding register i (i = 0..6) holds its default value. The default at the parameter defaults is 21'h100000 + i. No update pulse is seen.
- R2: Each rising edge of the serial clock shifts the serial data bit into the shift register, MSB first. Falling edges shift nothing. The last three bits of a 24-bit frame form the address, with address bit 0 being the final bit sent.
- R3: On a rising edge of the load strobe, the register whose index equals the address (0..6) takes frame bits [23:3].
- R4: A load changes no register other than the addressed one.
- R5: A load with address 7 changes no register and raises no update pulse.
- R6: A load raises exactly one update pulse, lasting one system-clock cycle. It appears on bit i of the update output, where i is the written register's index.
- R7: Keeping the load strobe high for many cycles produces one load only.
- R8: Serial-clock edges that arrive while the load strobe is high leave the shift register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_data | input | 1 | Serial data, asynchronous |
| ser_le | input | 1 | Load strobe, asynchronous |
| latch_q | output | 147 | Seven 21-bit registers, register i at bits [21*i +: 21] |
| latch_upd | output | 7 | One-cycle update pulse per register |

## Verification
Two functions can land in the same system-clock cycle: a serial-clock rising edge and the rising edge of the load strobe. The bench provokes this by raising both wires at the same instant after a full frame, with the data wire high. The loaded register must get the frame as it stood before that edge. A second load, made with no new bits shifted in, must deliver the same word again, which shows that the colliding edge did not shift a bit into the register.

// File: rtl/cfg_pkg.sv
// Shared constants for the serial configuration loader.
// Assumes the address field width and register count stay fixed.
package cfg_pkg;
    localparam int CFG_ADDR_W    = 3;
    localparam int CFG_NUM_LATCH = 7;
    typedef logic [CFG_ADDR_W-1:0] cfg_addr_t;
endpackage

// File: rtl/cfg_sync.sv
// Two-flop synchronizer plus rising-edge detector for a vector of
// asynchronous inputs. Assumes inputs stay stable for several clk cycles.
module cfg_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_bit
            logic s0, s1, prev;
            // Synchronize one bit and remember its previous synced value.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    s0   <= 1'b0;
                    s1   <= 1'b0;
                    prev <= 1'b0;
                end else begin
                    s0   <= async_in[g];
                    s1   <= s0;
                    prev <= s1;
                end
            end
            assign lvl[g]  = s1;
            assign rise[g] = s1 & ~prev;
        end
    endgenerate
endmodule

// File: rtl/cfg_shift.sv
// Serial-in shift register, MSB first. Shifts only when enabled.
// Assumes shift_en is a single-cycle pulse per serial bit.
module cfg_shift #(
    parameter int FRAME_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_en,
    input  logic               bit_in,
    output logic [FRAME_W-1:0] word
);
    // Clear on reset, shift new bit into the LSB when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            word <= '0;
        else if (shift_en)
            word <= {word[FRAME_W-2:0], bit_in};
    end
endmodule

// File: rtl/cfg_latch_bank.sv
// Bank of NUM holding registers with per-register update pulse.
// Addresses at or above NUM write nothing. Assumes load is single-cycle.
module cfg_latch_bank #(
    parameter int DW   = 21,
    parameter int NUM  = 7,
    parameter int AW   = 3,
    parameter logic [NUM*DW-1:0] INIT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     din,
    output logic [NUM*DW-1:0] q,
    output logic [NUM-1:0]    upd
);
    genvar g;
    generate
        for (g = 0; g < NUM; g++) begin : g_latch
            logic hit;
            assign hit = load && (addr == AW'(g));
            // Hold the register, reload default on reset, capture on hit.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q[g*DW +: DW] <= INIT[g*DW +: DW];
                    upd[g]        <= 1'b0;
                end else begin
                    upd[g] <= hit;
                    if (hit)
                        q[g*DW +: DW] <= din;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/ser_cfg_loader.sv
// Top of the serial configuration loader: synchronizes the three port
// wires, shifts data on serial-clock rises (suppressed while the load
// strobe is high), and on a load-strobe rise writes the payload into the
// register picked by the three trailing address bits.
module ser_cfg_loader #(
    parameter int FRAME_W = 24,
    parameter logic [cfg_pkg::CFG_NUM_LATCH*(FRAME_W-cfg_pkg::CFG_ADDR_W)-1:0] LATCH_INIT = {
        21'h100006, 21'h100005, 21'h100004, 21'h100003,
        21'h100002, 21'h100001, 21'h100000}
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk,
    input  logic ser_data,
    input  logic ser_le,
    output logic [cfg_pkg::CFG_NUM_LATCH*(FRAME_W-cfg_pkg::CFG_ADDR_W)-1:0] latch_q,
    output logic [cfg_pkg::CFG_NUM_LATCH-1:0] latch_upd
);
    import cfg_pkg::*;
    localparam int DW = FRAME_W - CFG_ADDR_W;

    logic [2:0]         s_lvl, s_rise;
    logic               le_lvl, le_rise, sclk_rise, shift_en;
    logic [FRAME_W-1:0] shift_word;
    cfg_addr_t          addr;

    cfg_sync #(.W(3)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .async_in({ser_le, ser_data, ser_clk}),
        .lvl(s_lvl), .rise(s_rise)
    );

    assign sclk_rise = s_rise[0];
    assign le_lvl    = s_lvl[2];
    assign le_rise   = s_rise[2];
    assign shift_en  = sclk_rise & ~le_lvl;

    cfg_shift #(.FRAME_W(FRAME_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en),
        .bit_in(s_lvl[1]), .word(shift_word)
    );

    assign addr = shift_word[CFG_ADDR_W-1:0];

    cfg_latch_bank #(.DW(DW), .NUM(CFG_NUM_LATCH), .AW(CFG_ADDR_W), .INIT(LATCH_INIT)) u_bank (
        .clk(clk), .rst_n(rst_n), .load(le_rise), .addr(addr),
        .din(shift_word[FRAME_W-1:CFG_ADDR_W]), .q(latch_q), .upd(latch_upd)
    );
endmodule

// File: rtl/ser_cfg_loader_chk.sv
// Property checker for ser_cfg_loader, attached by bind.
module ser_cfg_loader_chk #(
    parameter int FRAME_W = 24,
    parameter int NUM     = 7,
    parameter int DW      = 21
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM*DW-1:0]  latch_q,
    input logic [NUM-1:0]     latch_upd,
    input logic               le_lvl,
    input logic               le_rise,
    input logic               sclk_rise,
    input logic [FRAME_W-1:0] shift_word
);
    // R6
    upd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(latch_upd));
    // R6
    upd_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_upd != '0) |=> (latch_upd == '0));
    // R4
    stable_without_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_upd == '0) |-> $stable(latch_q));
    // R3
    load_hits_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (le_rise && shift_word[2:0] != 3'd7) |=> (latch_upd == (NUM'(1) << $past(shift_word[2:0]))));
    // R5
    addr7_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (le_rise && shift_word[2:0] == 3'd7) |=> (latch_upd == '0));
    // R8
    no_shift_in_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (le_lvl && sclk_rise) |=> $stable(shift_word));
endmodule

bind ser_cfg_loader ser_cfg_loader_chk #(.FRAME_W(FRAME_W), .NUM(7), .DW(FRAME_W-3)) u_chk (
    .clk(clk), .rst_n(rst_n), .latch_q(latch_q), .latch_upd(latch_upd),
    .le_lvl(le_lvl), .le_rise(le_rise), .sclk_rise(sclk_rise), .shift_word(shift_word)
);

// File: tb/ser_cfg_loader_bench.sv
module ser_cfg_loader_bench;
    localparam int CLK_PERIOD = 10;
    localparam int FW = 24;
    localparam int DW = 21;
    localparam int HALF = 4;

    logic clk = 0, rst_n = 0, ser_clk = 0, ser_data = 0, ser_le = 0;
    logic [7*DW-1:0] latch_q;
    logic [6:0]      latch_upd;
    logic [DW-1:0]   exp_q [7];
    int upd_cnt [7];
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    ser_cfg_loader u_ser_cfg_loader (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_le(ser_le), .latch_q(latch_q), .latch_upd(latch_upd)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Count update pulses away from the active edge.
    always @(negedge clk)
        for (int i = 0; i < 7; i++) if (rst_n && latch_upd[i]) upd_cnt[i]++;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic waitc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_cnt();
        for (int i = 0; i < 7; i++) upd_cnt[i] = 0;
    endtask

    task automatic check_all(string req);
        for (int i = 0; i < 7; i++)
            chk(req, 32'(latch_q[i*DW +: DW]), 32'(exp_q[i]));
    endtask

    task automatic send_frame(logic [FW-1:0] w);
        for (int b = FW-1; b >= 0; b--) begin
            ser_data = w[b];
            waitc(HALF); ser_clk = 1;
            waitc(HALF); ser_clk = 0;
        end
        waitc(HALF);
    endtask

    task automatic pulse_le(int hold);
        ser_le = 1; waitc(hold);
        ser_le = 0; waitc(HALF);
    endtask

    task automatic t_reset();
        waitc(2);
        check_all("R1 default");
        for (int i = 0; i < 7; i++) chk("R1 no pulse", upd_cnt[i], 0);
    endtask

    task automatic t_load_each();
        for (int a = 0; a < 7; a++) begin
            logic [DW-1:0] d = 21'h0ABCDE ^ DW'(a * 21'h031337);
            clear_cnt();
            send_frame({d, 3'(a)});
            pulse_le(8);
            exp_q[a] = d;
            check_all("R2 R3 R4 load");
            for (int i = 0; i < 7; i++)
                chk("R6 pulse count", upd_cnt[i], (i == a) ? 1 : 0);
        end
    endtask

    task automatic t_addr7();
        clear_cnt();
        send_frame({21'h1FFFFF, 3'd7});
        pulse_le(8);
        check_all("R5 addr7 ignored");
        for (int i = 0; i < 7; i++) chk("R5 no pulse", upd_cnt[i], 0);
    endtask

    task automatic t_hold();
        clear_cnt();
        send_frame({21'h055AA5, 3'd4});
        pulse_le(60);
        exp_q[4] = 21'h055AA5;
        chk("R7 single load", upd_cnt[4], 1);
        check_all("R7 value");
    endtask

    task automatic t_collide();
        clear_cnt();
        send_frame({21'h13579B, 3'd2});
        ser_data = 1;
        ser_clk = 1; ser_le = 1;
        waitc(8);
        exp_q[2] = 21'h13579B;
        chk("R8 collide load", 32'(latch_q[2*DW +: DW]), 32'(exp_q[2]));
        ser_le = 0; waitc(HALF);
        ser_clk = 0; waitc(HALF);
        pulse_le(8);
        chk("R8 shift untouched", 32'(latch_q[2*DW +: DW]), 32'(exp_q[2]));
        chk("R8 two loads", upd_cnt[2], 2);
    endtask

    initial begin
        for (int i = 0; i < 7; i++) begin exp_q[i] = DW'(21'h100000 + i); upd_cnt[i] = 0; end
        waitc(4);
        rst_n = 1;
        t_reset();
        t_load_each();
        t_addr7();
        t_hold();
        t_collide();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule